// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count of a storage-bus controller's DMA transfers. Software writes a 16-bit count as two bytes into a shadow copy. A command write with the DMA bit set copies that shadow into a live counter. When a transfer starts, the block works out how many bytes it will allow, which is the granted length. It then steps the live counter and a remaining-length register down as data beats move. When the transfer finishes it raises terminal count.

The granted length is the live count, where zero stands for 65536, clipped by a limit. That limit is the bytes left in the current bus phase. While a command is being collected, the limit is 32 bytes instead. The last beat either finishes the transfer at once or waits for the data source. It waits when the beat has used up the source's bytes, and then finishes on the source's next data-available or done event.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the live count bytes, granted length, remaining length, terminal-count flag, busy and done pulse all read zero.
- R2: A write at offset 0 (low byte) or offset 1 (mid byte) clears the terminal-count flag and updates only the shadow. The live count is unchanged, even during an active transfer.
- R3: A write at offset 3 (command) with bit 7 set copies both shadow bytes into the live count on the next cycle. With bit 7 clear, the live count is unchanged.
- R4: At transfer start, a live count of zero is taken as 65536. The live counter is loaded with 65536, so a following one-byte beat leaves 0xFFFF.
- R5: When no command is being collected, the granted length is the smaller of the effective count and the phase remaining byte count.
- R6: While a command is being collected, the granted length is the smaller of the effective count and 32.
- R7: A start clears terminal count and loads the remaining length with the grant. Busy goes high when the grant is nonzero. A zero grant leaves busy low and the transfer never completes.
- R8: Each beat during a transfer lowers both the remaining length and the live count by the beat's byte count, saturating at zero.
- R9: A beat that brings the remaining length to zero while the source is not empty completes the transfer in that same cycle. After it, terminal count is 1, the live count is 0, busy is 0, and the done pulse is high for exactly one cycle.
- R10: If the source is empty when the remaining length reaches zero, completion is deferred. Busy stays high and terminal count stays low until a source event arrives, and completion then follows as in R9.
- R11: A start during an active transfer replaces it with a new grant taken from the current live count and limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register offset (0 low count, 1 mid count, 3 command) |
| wrData | input | 8 | Register write data |
| xferStart | input | 1 | Transfer start pulse |
| collecting | input | 1 | A command is being collected |
| phaseRemain | input | 17 | Absolute byte count left in the bus phase |
| beatValid | input | 1 | A data beat moved this cycle |
| beatBytes | input | 8 | Bytes moved by the beat |
| srcEmpty | input | 1 | Data source has no unconsumed bytes |
| srcEvent | input | 1 | Source data-available or done event |
| liveLo | output | 8 | Live count low byte |
| liveMid | output | 8 | Live count mid byte |
| grantLen | output | 17 | Granted transfer length |
| remainLen | output | 17 | Bytes left in the grant |
| tcFlag | output | 1 | Terminal-count status bit |
| busy | output | 1 | Transfer in progress |
| donePulse | output | 1 | One-cycle completion (interrupt raise) strobe |

## Verification
Faults in the internal state all show at the ports within one cycle:
- A corrupted shadow appears on the live bytes one cycle after the next DMA command.
- A wrong clip or a mishandled zero count shows on grantLen the cycle after a start. A mishandled zero count also shows on the live bytes after one small beat.
- A wrap in the saturating subtraction shows as a large remainLen instead of zero.
- A completion-state error shows as busy and tcFlag disagreeing with whether a source event has arrived.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_WAIT = 2'd2
  } xferState_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic wrLo;
    logic wrMid;
    logic reload;
    logic start;
    logic step;
    logic finish;
  } xferStrobes_t;

  localparam logic [3:0] OFS_LO  = 4'd0;
  localparam logic [3:0] OFS_MID = 4'd1;
  localparam logic [3:0] OFS_CMD = 4'd3;

endpackage

// File: rtl/xfer_count_dp.sv
module xfer_count_dp
  import xfer_count_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BEAT_W  = 8,
  parameter int CMD_CAP = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xferStrobes_t         stb,
  input  logic [7:0]           wrData,
  input  logic                 collecting,
  input  logic [CNT_W:0]       phaseRemain,
  input  logic [BEAT_W-1:0]    beatBytes,
  output logic [CNT_W:0]       liveCnt,
  output logic [CNT_W:0]       grantLen,
  output logic [CNT_W:0]       remainLen,
  output logic                 grantZero,
  output logic                 lastBeat
);

  localparam int EFF_W = CNT_W + 1;
  localparam logic [EFF_W-1:0] FULL_CNT = EFF_W'(1) << CNT_W;
  localparam logic [EFF_W-1:0] CAP_VAL  = EFF_W'(CMD_CAP);

  logic [7:0]       shadowLo;
  logic [7:0]       shadowMid;
  logic [EFF_W-1:0] beatExt;
  logic [EFF_W-1:0] effCnt;
  logic [EFF_W-1:0] limitVal;
  logic [EFF_W-1:0] nextGrant;
  logic [EFF_W-1:0] liveSub;
  logic [EFF_W-1:0] remainSub;

  assign beatExt   = {{(EFF_W-BEAT_W){1'b0}}, beatBytes};
  assign effCnt    = (liveCnt == '0) ? FULL_CNT : liveCnt;
  assign limitVal  = collecting ? CAP_VAL : phaseRemain;
  assign nextGrant = (effCnt < limitVal) ? effCnt : limitVal;
  assign grantZero = (nextGrant == '0);
  assign liveSub   = (liveCnt > beatExt) ? (liveCnt - beatExt) : '0;
  assign remainSub = (remainLen > beatExt) ? (remainLen - beatExt) : '0;
  assign lastBeat  = (remainLen <= beatExt);

  // Shadow count bytes, written by the host only.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowLo  <= '0;
      shadowMid <= '0;
    end else begin
      if (stb.wrLo)  shadowLo  <= wrData;
      if (stb.wrMid) shadowMid <= wrData;
    end
  end

  // Live counter: completion beats reload beats start beats step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
    end else if (stb.finish) begin
      liveCnt <= '0;
    end else if (stb.reload) begin
      liveCnt <= {1'b0, shadowMid, shadowLo};
    end else if (stb.start) begin
      liveCnt <= effCnt;
    end else if (stb.step) begin
      liveCnt <= liveSub;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantLen  <= '0;
      remainLen <= '0;
    end else if (stb.start) begin
      grantLen  <= nextGrant;
      remainLen <= nextGrant;
    end else if (stb.step) begin
      remainLen <= remainSub;
    end
  end

  // R8
  remain_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.start) |=> (remainLen <= $past(remainLen)));

  // R6
  collect_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && collecting) |=> (grantLen <= CAP_VAL));

  // R9
  finish_zero_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (liveCnt == '0));

  // R2
  shadow_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.wrLo || stb.wrMid) && !stb.reload && !stb.start && !stb.step && !stb.finish)
      |=> (liveCnt == $past(liveCnt)));

endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl
  import xfer_count_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic          dmaBit,
  input  logic          xferStart,
  input  logic          beatValid,
  input  logic          srcEmpty,
  input  logic          srcEvent,
  input  logic          grantZero,
  input  logic          lastBeat,
  output xferStrobes_t  stb,
  output logic          tcFlag,
  output logic          busy,
  output logic          donePulse
);

  xferState_t state;
  xferState_t stateNext;
  logic       cntWr;

  assign cntWr = wrEn && ((wrAddr == OFS_LO) || (wrAddr == OFS_MID));

  always_comb begin
    stb        = '0;
    stb.wrLo   = wrEn && (wrAddr == OFS_LO);
    stb.wrMid  = wrEn && (wrAddr == OFS_MID);
    stb.reload = wrEn && (wrAddr == OFS_CMD) && dmaBit;
    stb.start  = xferStart;
    stb.step   = !xferStart && beatValid && (state == ST_MOVE);
    stb.finish = !xferStart &&
                 ((stb.step && lastBeat && !srcEmpty) ||
                  ((state == ST_WAIT) && srcEvent));
  end

  always_comb begin
    stateNext = state;
    if (stb.start) begin
      stateNext = grantZero ? ST_IDLE : ST_MOVE;
    end else if (stb.finish) begin
      stateNext = ST_IDLE;
    end else if (stb.step && lastBeat) begin
      stateNext = ST_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tcFlag    <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      donePulse <= stb.finish;
      if (cntWr || stb.start) begin
        tcFlag <= 1'b0;
      end else if (stb.finish) begin
        tcFlag <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R2
  tc_clear_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> !tcFlag);

  // R9
  done_sets_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && !cntWr) |=> (tcFlag && donePulse && !busy));

  // R10
  wait_no_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !donePulse) |-> !tcFlag || $past(tcFlag));

  // R7
  start_clears_tc_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !tcFlag);

endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xfer_count_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BEAT_W  = 8,
  parameter int CMD_CAP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic              xferStart,
  input  logic              collecting,
  input  logic [CNT_W:0]    phaseRemain,
  input  logic              beatValid,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic              srcEmpty,
  input  logic              srcEvent,
  output logic [7:0]        liveLo,
  output logic [7:0]        liveMid,
  output logic [CNT_W:0]    grantLen,
  output logic [CNT_W:0]    remainLen,
  output logic              tcFlag,
  output logic              busy,
  output logic              donePulse
);

  xferStrobes_t  stb;
  logic          grantZero;
  logic          lastBeat;
  logic [CNT_W:0] liveCnt;

  xfer_count_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .dmaBit    (wrData[7]),
    .xferStart (xferStart),
    .beatValid (beatValid),
    .srcEmpty  (srcEmpty),
    .srcEvent  (srcEvent),
    .grantZero (grantZero),
    .lastBeat  (lastBeat),
    .stb       (stb),
    .tcFlag    (tcFlag),
    .busy      (busy),
    .donePulse (donePulse)
  );

  xfer_count_dp #(
    .CNT_W   (CNT_W),
    .BEAT_W  (BEAT_W),
    .CMD_CAP (CMD_CAP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .collecting  (collecting),
    .phaseRemain (phaseRemain),
    .beatBytes   (beatBytes),
    .liveCnt     (liveCnt),
    .grantLen    (grantLen),
    .remainLen   (remainLen),
    .grantZero   (grantZero),
    .lastBeat    (lastBeat)
  );

  assign liveLo  = liveCnt[7:0];
  assign liveMid = liveCnt[15:8];

endmodule

// File: tb/xfer_count_unit_test.sv
module xfer_count_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  mid;
    logic [16:0] phase;
    logic        coll;
    logic [16:0] expGrant;
  } vec_t;

  // R4 R5 R6 vectors: count bytes, phase remaining, collecting, expected grant
  localparam vec_t VECS [NVEC] = '{
    '{8'h10, 8'h00, 17'd100,   1'b0, 17'd16},
    '{8'h34, 8'h12, 17'h40,    1'b0, 17'h40},
    '{8'h00, 8'h00, 17'h1FFFF, 1'b0, 17'h10000},
    '{8'h00, 8'h01, 17'd900,   1'b1, 17'd32},
    '{8'h05, 8'h00, 17'd900,   1'b1, 17'd5},
    '{8'h00, 8'h00, 17'd70000, 1'b0, 17'd65536}
  };

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [3:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic xferStart = 0;
  logic collecting = 0;
  logic [16:0] phaseRemain = 0;
  logic beatValid = 0;
  logic [7:0] beatBytes = 0;
  logic srcEmpty = 0;
  logic srcEvent = 0;
  logic [7:0] liveLo, liveMid;
  logic [16:0] grantLen, remainLen;
  logic tcFlag, busy, donePulse;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_count_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .xferStart(xferStart), .collecting(collecting), .phaseRemain(phaseRemain),
    .beatValid(beatValid), .beatBytes(beatBytes), .srcEmpty(srcEmpty),
    .srcEvent(srcEvent), .liveLo(liveLo), .liveMid(liveMid),
    .grantLen(grantLen), .remainLen(remainLen), .tcFlag(tcFlag),
    .busy(busy), .donePulse(donePulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic startX(input logic [16:0] ph, input logic c);
    @(negedge clk);
    xferStart = 1; phaseRemain = ph; collecting = c;
    @(negedge clk);
    xferStart = 0;
  endtask

  task automatic beat(input logic [7:0] n, input logic empty);
    @(negedge clk);
    beatValid = 1; beatBytes = n; srcEmpty = empty;
    @(negedge clk);
    beatValid = 0; srcEmpty = 0;
  endtask

  task automatic srcEv();
    @(negedge clk);
    srcEvent = 1;
    @(negedge clk);
    srcEvent = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 live", {liveMid, liveLo}, 0);
    chk("R1 grant", grantLen, 0);
    chk("R1 remain", remainLen, 0);
    chk("R1 flags", {tcFlag, busy, donePulse}, 0);

    for (int i = 0; i < NVEC; i++) begin
      regWr(4'd0, VECS[i].lo);
      regWr(4'd1, VECS[i].mid);
      regWr(4'd3, 8'h90);
      chk("R3 reload", {liveMid, liveLo}, {VECS[i].mid, VECS[i].lo});
      startX(VECS[i].phase, VECS[i].coll);
      chk(VECS[i].coll ? "R6 grant" : "R5 grant", grantLen, VECS[i].expGrant);
      chk("R7 busy", busy, 1);
      chk("R7 remain", remainLen, VECS[i].expGrant);
    end

    // R4 zero count taken as 65536; a one-byte beat leaves 0xFFFF
    beat(8'd1, 1'b0);
    chk("R4 live after beat", {liveMid, liveLo}, 16'hFFFF);

    // R3 command without bit 7 leaves live alone
    regWr(4'd0, 8'h55);
    regWr(4'd3, 8'h10);
    chk("R3 no reload", {liveMid, liveLo}, 16'hFFFF);

    // R9 immediate completion
    regWr(4'd0, 8'h02); regWr(4'd1, 8'h00); regWr(4'd3, 8'h90);
    startX(17'd100, 1'b0);
    chk("R7 tc cleared by start", tcFlag, 0);
    @(negedge clk);
    beatValid = 1; beatBytes = 8'd2; srcEmpty = 0;
    @(negedge clk);
    beatValid = 0;
    chk("R9 tc", tcFlag, 1);
    chk("R9 live", {liveMid, liveLo}, 0);
    chk("R9 busy", busy, 0);
    chk("R9 done", donePulse, 1);
    @(negedge clk);
    chk("R9 done one cycle", donePulse, 0);

    // R2 count write clears tc, shadow only
    regWr(4'd1, 8'h07);
    chk("R2 tc clear", tcFlag, 0);
    chk("R2 live unchanged", {liveMid, liveLo}, 0);

    // R8 R10 saturation and deferred completion
    regWr(4'd0, 8'h00); regWr(4'd1, 8'h01); regWr(4'd3, 8'h80);
    startX(17'd5, 1'b0);
    chk("R5 grant small phase", grantLen, 5);
    beat(8'd2, 1'b0);
    chk("R8 remain", remainLen, 3);
    chk("R8 live", {liveMid, liveLo}, 16'h00FE);
    // R2 write during transfer does not touch live
    regWr(4'd0, 8'hAA);
    chk("R2 live during busy", {liveMid, liveLo}, 16'h00FE);
    beat(8'd200, 1'b1);
    chk("R8 remain saturates", remainLen, 0);
    chk("R8 live", {liveMid, liveLo}, 16'h0036);
    chk("R10 still busy", busy, 1);
    chk("R10 no tc", tcFlag, 0);
    @(negedge clk);
    chk("R10 waits", {busy, tcFlag, donePulse}, 3'b100);
    srcEv();
    chk("R10 completes", {busy, tcFlag, donePulse}, 3'b011);
    chk("R10 live zero", {liveMid, liveLo}, 0);

    // R11 restart replaces, R7 zero grant
    regWr(4'd0, 8'h40); regWr(4'd1, 8'h00); regWr(4'd3, 8'h80);
    startX(17'd10, 1'b0);
    startX(17'd20, 1'b0);
    chk("R11 new grant", grantLen, 20);
    chk("R11 remain", remainLen, 20);
    startX(17'd0, 1'b0);
    chk("R7 zero grant idle", busy, 0);
    chk("R7 zero grant", grantLen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule